// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash bus transaction each time software writes its command register. Each transaction moves through a fixed order of byte phases on a half-duplex SPI bus in mode 3: an opcode byte, zero to three address bytes, zero to fifteen dummy bytes, and zero to four data bytes. The data bytes are either sent or captured. A small register bus gives access to the command word, the address, the data word, the status flags, the serial clock timing, and the idle levels of the two spare flash lines.

A command can leave its chip select asserted when it ends. The next command then continues the same bus transfer. It skips the opcode and starts at its first non-empty phase, so a long read or program can be split into chunks of up to four data bytes. A command that finds the chip select already open, has all three lengths at zero and has keep cleared sends nothing and only closes the transfer.

The controller is a six-state machine. IDLE waits for a command write. An accepted write moves to OPCODE when no transfer is open. When a transfer is open, it moves to the first phase with a non-zero length, or to FINISH if every length is zero. Each byte state stays put until its count of bytes is shifted, then goes on in the order OPCODE, ADDR, DUMMY, DATA, skipping empty phases, and ends in FINISH. FINISH applies the keep bit to the chip select and returns to IDLE after one cycle.

Top module: `sflash_seq`

## Requirements
- R1: Command word fields are: opcode in bits 7:0; direction in bit 8 (1 = write); data length in bits 11:9 (values above 4 act as 4); keep-select in bit 15; dummy count in bits 19:16; address length in bits 22:20 (values above 3 act as 3); select number in bits 26:24. The command register reads back the last accepted word.
- R2: The bus carries, in this order: the opcode, then the address bytes most significant first, then the dummy bytes, then the data bytes. The address bytes are taken from the low bytes of the address register (register index 1). Phases of zero length are skipped.
- R3: The data register (index 2) packs the bytes so that bits 7:0 are the first byte on the bus. A read stores the captured bytes in the same order and clears the bytes it does not fill.
- R4: Status (index 3) bit 22 reads 1 from the cycle after an accepted command write until the command ends. Status bit 29 is cleared by writing 1 to it.
- R5: With keep set, the chip select stays low after the command and the next command sends no opcode. With keep cleared, all chip selects are high once the command ends.
- R6: A command with zero address, dummy and data lengths and keep cleared, issued while a transfer is open, produces no serial clock edges and only releases the chip select.
- R7: Timing (index 4) holds the bit period in bits 3:0, the rising-edge position in bits 11:8 and the falling-edge position in bits 15:12, counted in core clocks. Each byte takes 8 periods plus one cycle, and SCK is low for (rise minus fall) cycles per bit.
- R8: SCK idles high. MOSI changes only on the falling edge of SCK. MISO is sampled on the rising edge.
- R9: Bits 3:2 of the I/O register (index 5) drive the idle levels of the spare write-protect and hold lines. Both levels reset to 1.
- R10: A command write that arrives while a command is pending is dropped and sets the error flag.
- R11: Dummy bytes shift out 0x00 and the captured value is discarded. During a write data phase the data register keeps the value software wrote.
- R12: At most one chip select is low at a time. It is the one numbered by the command that opened the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | NUM_CS | Active-low chip selects |
| aux_lvl | output | 2 | Idle levels: [0] write-protect, [1] hold |

## Verification
A command accepted at clock edge T keeps the pending flag set until edge T + n(8P+1) + 1. Here n is the number of bytes the command puts on the bus and P is the bit period. The chip select and SCK settle to their idle values at that same edge. The bench keeps a countdown loaded with this figure at the write edge. After each edge it compares the pending flag, the SCK idle level and the expected chip select levels against that countdown. A behavioural flash on the serial pins logs each byte and returns a known pattern. The bench compares this log and the data register only after the countdown reaches zero. It counts SCK-low cycles to confirm the edge positions.

// File: rtl/sflash_seq_pkg.sv
package sflash_seq_pkg;

    localparam int RIDX_CMD  = 0;
    localparam int RIDX_ADDR = 1;
    localparam int RIDX_DATA = 2;
    localparam int RIDX_STAT = 3;
    localparam int RIDX_TIME = 4;
    localparam int RIDX_IO   = 5;

    localparam int PEND_BIT  = 22;
    localparam int ERR_BIT   = 29;

    localparam logic [15:0] TIME_RESET = 16'h0102;
    localparam logic [3:0]  IO_RESET   = 4'hC;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_DUMMY, ST_DATA, ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [2:0] cs;
        logic [2:0] alen;
        logic [3:0] dum;
        logic       keep;
        logic [2:0] dlen;
        logic       wr;
        logic [7:0] opcode;
    } cmd_t;

    function automatic cmd_t cmd_decode(input logic [31:0] w);
        cmd_t c;
        c.opcode = w[7:0];
        c.wr     = w[8];
        c.dlen   = (w[11:9] > 3'd4) ? 3'd4 : w[11:9];
        c.keep   = w[15];
        c.dum    = w[19:16];
        c.alen   = (w[22:20] > 3'd3) ? 3'd3 : w[22:20];
        c.cs     = w[26:24];
        return c;
    endfunction

    function automatic seq_state_e phase_after(input seq_state_e cur, input cmd_t c);
        seq_state_e n = ST_FINISH;
        if ((cur == ST_OPCODE || cur == ST_ADDR || cur == ST_DUMMY) && c.dlen != 3'd0)
            n = ST_DATA;
        if ((cur == ST_OPCODE || cur == ST_ADDR) && c.dum != 4'd0)
            n = ST_DUMMY;
        if (cur == ST_OPCODE && c.alen != 3'd0)
            n = ST_ADDR;
        return n;
    endfunction

    function automatic logic [3:0] phase_len(input seq_state_e st, input cmd_t c);
        logic [3:0] l;
        unique case (st)
            ST_OPCODE: l = 4'd1;
            ST_ADDR:   l = {1'b0, c.alen};
            ST_DUMMY:  l = c.dum;
            ST_DATA:   l = {1'b0, c.dlen};
            default:   l = 4'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/sflash_seq_shifter.sv
module sflash_seq_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic [3:0] per,
    input  logic [3:0] rise,
    input  logic [3:0] fall,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic       busy_q;
    logic [3:0] cnt_q;
    logic [2:0] bit_q;
    logic [7:0] sh_q;
    logic [3:0] last_cnt;

    // a period below two cycles cannot hold both edges
    assign last_cnt = (per < 4'd2) ? 4'd1 : per - 4'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            sck     <= 1'b1;
            mosi    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                bit_q  <= '0;
                sh_q   <= tx_byte;
            end else if (busy_q) begin
                if (cnt_q == fall) begin
                    sck  <= 1'b0;
                    mosi <= sh_q[7];
                end
                if (cnt_q == rise) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                    sh_q    <= {sh_q[6:0], 1'b0};
                end
                if (cnt_q == last_cnt) begin
                    cnt_q <= '0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                        sck    <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end else begin
                    cnt_q <= cnt_q + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/sflash_seq_csdec.sv
module sflash_seq_csdec #(
    parameter int NUM_CS = 3
) (
    input  logic              en,
    input  logic [2:0]        sel,
    output logic [NUM_CS-1:0] cs_n
);
    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            assign cs_n[i] = !(en && (sel == 3'(i)));
        end
    endgenerate
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
    import sflash_seq_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic [1:0]        aux_lvl
);
    localparam int IDX_W = 4;

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [31:0]       cmd_raw_q, addr_q, data_q;
    logic [15:0]       time_q;
    logic [3:0]        io_q;
    logic              err_q, cs_on_q;
    logic [2:0]        cs_sel_q;
    cmd_t              cmd_q, cmd_sel;
    logic              sel_cmd, sel_stat, accept, busy_w, fin_w, keep_w;
    logic              start, sh_done;
    logic [7:0]        tx_byte, rx_byte;

    assign cmd_q    = cmd_decode(cmd_raw_q);
    assign sel_cmd  = reg_wr && (reg_addr == REG_AW'(RIDX_CMD));
    assign sel_stat = reg_wr && (reg_addr == REG_AW'(RIDX_STAT));
    assign busy_w   = (state_q != ST_IDLE);
    assign accept   = sel_cmd && !busy_w;
    assign cmd_sel  = busy_w ? cmd_q : cmd_decode(reg_wdata);
    assign fin_w    = (state_q == ST_FINISH);
    assign keep_w   = cmd_q.keep;
    assign aux_lvl  = io_q[3:2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state and byte launch
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = cs_on_q ? phase_after(ST_OPCODE, cmd_sel) : ST_OPCODE;
                    idx_d   = '0;
                    start   = (state_d != ST_FINISH);
                end
            end
            ST_OPCODE, ST_ADDR, ST_DUMMY, ST_DATA: begin
                if (sh_done) begin
                    if (idx_q + 4'd1 < phase_len(state_q, cmd_q)) begin
                        idx_d = idx_q + 4'd1;
                    end else begin
                        state_d = phase_after(state_q, cmd_q);
                        idx_d   = '0;
                    end
                    start = (state_d != ST_FINISH);
                end
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // byte to put on the wire next
    always_comb begin
        int unsigned ab;
        ab = 32'(cmd_sel.alen) - 32'd1 - 32'(idx_d);
        unique case (state_d)
            ST_OPCODE: tx_byte = cmd_sel.opcode;
            ST_ADDR:   tx_byte = (ab < 32'd4) ? addr_q[8*ab +: 8] : 8'h00;
            ST_DATA:   tx_byte = cmd_sel.wr ? data_q[8*idx_d[1:0] +: 8] : 8'h00;
            default:   tx_byte = 8'h00;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_raw_q <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            time_q    <= TIME_RESET;
            io_q      <= IO_RESET;
            err_q     <= 1'b0;
            cs_on_q   <= 1'b0;
            cs_sel_q  <= '0;
        end else begin
            if (accept) begin
                cmd_raw_q <= reg_wdata;
                if (!cs_on_q) begin
                    cs_on_q  <= 1'b1;
                    cs_sel_q <= cmd_sel.cs;
                end
                if (!cmd_sel.wr)
                    data_q <= '0;
            end else if (sel_cmd) begin
                err_q <= 1'b1;
            end
            if (sel_stat && reg_wdata[ERR_BIT])
                err_q <= 1'b0;
            if (reg_wr && !busy_w) begin
                if (reg_addr == REG_AW'(RIDX_ADDR)) addr_q <= reg_wdata;
                if (reg_addr == REG_AW'(RIDX_DATA)) data_q <= reg_wdata;
                if (reg_addr == REG_AW'(RIDX_TIME)) time_q <= reg_wdata[15:0];
            end
            if (reg_wr && reg_addr == REG_AW'(RIDX_IO))
                io_q <= reg_wdata[3:0];
            if (state_q == ST_DATA && sh_done && !cmd_q.wr)
                data_q[8*idx_q[1:0] +: 8] <= rx_byte;
            if (fin_w)
                cs_on_q <= cmd_q.keep;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(RIDX_CMD))  reg_rdata = cmd_raw_q;
        if (reg_addr == REG_AW'(RIDX_ADDR)) reg_rdata = addr_q;
        if (reg_addr == REG_AW'(RIDX_DATA)) reg_rdata = data_q;
        if (reg_addr == REG_AW'(RIDX_STAT)) begin
            reg_rdata[PEND_BIT] = busy_w;
            reg_rdata[ERR_BIT]  = err_q;
        end
        if (reg_addr == REG_AW'(RIDX_TIME)) reg_rdata = {16'h0, time_q};
        if (reg_addr == REG_AW'(RIDX_IO))   reg_rdata = {28'h0, io_q};
    end

    sflash_seq_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (tx_byte),
        .per     (time_q[3:0]),
        .rise    (time_q[11:8]),
        .fall    (time_q[15:12]),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    sflash_seq_csdec #(.NUM_CS(NUM_CS)) u_csdec (
        .en   (cs_on_q),
        .sel  (cs_sel_q),
        .cs_n (cs_n)
    );
endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk #(
    parameter int NUM_CS = 3,
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              pending,
    input logic              err,
    input logic              fin,
    input logic              keep
);
    p_one_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> sck);

    p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(0) && !pending) |=> pending);

    p_clear_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(3) && reg_wdata[29]) |=> !err);

    p_busy_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(0) && pending) |=> err);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !keep) |=> (&cs_n));
endmodule

bind sflash_seq sflash_seq_chk #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .pending   (busy_w),
    .err       (err_q),
    .fin       (fin_w),
    .keep      (keep_w)
);

// File: tb/sflash_seq_tb_top.sv
module sflash_seq_tb_top;
    localparam int A_CMD = 0, A_ADDR = 1, A_DATA = 2, A_STAT = 3, A_TIME = 4, A_IO = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'(A_STAT);
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, mosi;
    logic        miso = 1'b0;
    logic [2:0]  cs_n;
    logic [1:0]  aux_lvl;

    always #10 clk = ~clk;

    sflash_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .aux_lvl(aux_lvl)
    );

    int n_chk = 0, n_fail = 0;
    int bit_per = 2;
    int rem = 0, ld_val = 0, low_cnt = 0;
    bit ld = 1'b0, fin_run = 1'b0;
    logic [2:0] exp_cs = 3'b111, exp_cs_after = 3'b111;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 29 + 90) & 255);
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] opc, input bit wr, input int dlen,
                                       input bit keep, input int dum, input int alen, input int cs);
        return {5'b0, 3'(cs), 1'b0, 3'(alen), 4'(dum), keep, 3'b0, 3'(dlen), wr, opc};
    endfunction

    // behavioural flash: logs bytes, returns pattern bytes
    logic [7:0] rec[$];
    int fbit = 0, fbyte = 0;
    logic [7:0] fsh = '0;
    wire all_hi = &cs_n;
    always @(posedge sck) if (!all_hi) begin
        fsh = {fsh[6:0], mosi};
        fbit++;
        if (fbit == 8) begin rec.push_back(fsh); fbit = 0; fbyte++; end
    end
    always @(negedge sck) if (!all_hi) begin
        logic [7:0] p;
        p = pat(fbyte);
        miso = p[7 - fbit];
    end
    always @(posedge all_hi) begin fbit = 0; fbyte = 0; end

    // reference countdown, one step per clock edge
    always @(posedge clk) begin
        if (ld) begin rem = ld_val; ld = 1'b0; end
        else if (rem > 0) begin
            rem--;
            if (rem == 0) exp_cs = exp_cs_after;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        #2;
        if (rst_n && !fin_run) begin
            if (!sck) low_cnt++;
            if (!reg_wr && reg_addr == 3'(A_STAT))
                chk("R4 pending flag", 32'(reg_rdata[22]), 32'(rem > 0));
            if (rem == 0) begin
                chk("R8 sck idle high", 32'(sck), 32'd1);
                chk("R5/R12 chip select idle", 32'(cs_n), 32'(exp_cs));
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d, input bit load, input int n);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        if (load) begin ld = 1'b1; ld_val = n * (8 * bit_per + 1) + 1; end
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'(A_STAT);
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 3'(a);
        #3 v = reg_rdata;
        @(negedge clk);
        reg_addr = 3'(A_STAT);
    endtask

    task automatic run_cmd(input logic [31:0] w, input int n, input logic [2:0] cs_after);
        exp_cs_after = cs_after;
        wr(A_CMD, w, 1'b1, n);
        while (rem > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_rec(input string req, input logic [7:0] e[$]);
        chk({req, " byte count"}, 32'(rec.size()), 32'(e.size()));
        if (rec.size() == e.size())
            foreach (e[i]) chk(req, 32'(rec[i]), 32'(e[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0] e[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        rd(A_STAT, v); chk("R4 status after reset", v, 32'h0);
        chk("R12 selects after reset", 32'(cs_n), 32'h7);
        chk("R9 spare levels after reset", 32'(aux_lvl), 32'h3);
        rd(A_TIME, v); chk("R7 timing after reset", v, 32'h0102);

        // plain read: opcode, 3 address bytes, 4 data bytes
        rec.delete();
        wr(A_ADDR, 32'h00123456, 1'b0, 0);
        run_cmd(mk(8'h03, 0, 4, 0, 0, 3, 0), 8, 3'b111);
        e = {8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00};
        chk_rec("R2 read sequence", e);
        rd(A_DATA, v); chk("R3 read packing", v, {pat(7), pat(6), pat(5), pat(4)});
        rd(A_CMD, v); chk("R1 command readback", v, mk(8'h03, 0, 4, 0, 0, 3, 0));

        // slow clock with one dummy byte on select 1
        rec.delete();
        bit_per = 12;
        wr(A_TIME, 32'h0000060C, 1'b0, 0);
        wr(A_ADDR, 32'h00ABCDEF, 1'b0, 0);
        low_cnt = 0;
        exp_cs_after = 3'b111;
        wr(A_CMD, mk(8'h0B, 0, 2, 0, 1, 3, 1), 1'b1, 7);
        repeat (5) @(negedge clk);
        chk("R12 select 1 driven", 32'(cs_n), 32'h5);
        while (rem > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R7 sck low cycles", 32'(low_cnt), 32'(7 * 8 * 6));
        e = {8'h0B, 8'hAB, 8'hCD, 8'hEF, 8'h00, 8'h00, 8'h00};
        chk_rec("R11 dummy sends zero", e);
        rd(A_DATA, v); chk("R11 dummy capture discarded", v, {16'h0, pat(6), pat(5)});
        bit_per = 2;
        wr(A_TIME, 32'h00000102, 1'b0, 0);

        // write split into three chunks, select 2 held
        rec.delete();
        wr(A_ADDR, 32'h00000100, 1'b0, 0);
        run_cmd(mk(8'h02, 1, 0, 1, 0, 3, 2), 4, 3'b011);
        chk("R5 select held after keep", 32'(cs_n), 32'h3);
        wr(A_DATA, 32'h44332211, 1'b0, 0);
        run_cmd(mk(8'h77, 1, 4, 1, 0, 0, 2), 4, 3'b011);
        wr(A_DATA, 32'h00006655, 1'b0, 0);
        run_cmd(mk(8'h77, 1, 2, 0, 0, 0, 2), 2, 3'b111);
        e = {8'h02, 8'h00, 8'h01, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        chk_rec("R5 chunked write without opcode resend", e);
        rd(A_DATA, v); chk("R11 write keeps data register", v, 32'h00006655);

        // held read then a bare release
        rec.delete();
        run_cmd(mk(8'h05, 0, 1, 1, 0, 0, 0), 2, 3'b110);
        rd(A_DATA, v); chk("R3 single byte read", v, {24'h0, pat(1)});
        low_cnt = 0;
        run_cmd(32'h0, 0, 3'b111);
        chk("R6 no clocks on release", 32'(low_cnt), 32'h0);
        chk("R6 selects released", 32'(cs_n), 32'h7);
        chk("R6 nothing shifted", 32'(rec.size()), 32'd2);

        // command write while pending
        rec.delete();
        exp_cs_after = 3'b111;
        wr(A_CMD, mk(8'h9F, 0, 3, 0, 0, 0, 1), 1'b1, 4);
        repeat (4) @(negedge clk);
        wr(A_CMD, mk(8'hAB, 1, 4, 1, 0, 3, 0), 1'b0, 0);
        while (rem > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        rd(A_STAT, v); chk("R10 error flag set", v, 32'h20000000);
        e = {8'h9F, 8'h00, 8'h00, 8'h00};
        chk_rec("R10 busy write dropped", e);
        rd(A_DATA, v); chk("R10 read data intact", v, {8'h0, pat(3), pat(2), pat(1)});
        wr(A_STAT, 32'h20000000, 1'b0, 0);
        rd(A_STAT, v); chk("R4 error cleared by one", v, 32'h0);

        // opcode-only command
        rec.delete();
        run_cmd(mk(8'h06, 1, 0, 0, 0, 0, 0), 1, 3'b111);
        e = {8'h06};
        chk_rec("R2 opcode only", e);

        // spare line levels
        wr(A_IO, 32'h0, 1'b0, 0);
        @(negedge clk); chk("R9 spare levels low", 32'(aux_lvl), 32'h0);
        wr(A_IO, 32'h4, 1'b0, 0);
        @(negedge clk); chk("R9 write-protect level", 32'(aux_lvl), 32'h1);

        fin_run = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule